// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block turns a system physical byte address into three things: the memory channel that holds it, the byte address inside that channel, and the rank within that channel. Each channel can hold up to four ranks. Software gives the capacity of every rank as a small code. From the two channel totals the block works out one of four ways of spreading addresses over the channels. With one channel populated, everything goes to that channel. With equal totals, cache lines alternate between the channels. With unequal totals, a configuration bit picks one of two layouts. The stacked layout fills channel 0 and then continues into channel 1. The L-shaped layout interleaves a low zone and puts the remaining upper memory on the larger channel only.

The translation is combinational. The result is captured in one output register stage, which is loaded whenever an input address is marked valid. An address beyond the populated memory is flagged rather than mapped.

Top module: `dcam_addr_mapper`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `out_chan`, `out_addr`, `out_rank`, `out_oor` and `out_mode` are all zero until the first valid input.
- R2: A request with `in_valid` high at a rising edge is reflected on the outputs with `out_valid` high after that edge. An edge with `in_valid` low drops `out_valid` and leaves every other output unchanged.
- R3: Rank k of a channel is coded in `cfg_capN` bits [2k+1:2k]. Code 0 means empty, 1 means 256 MB, 2 means 512 MB, and 3 is reserved and treated as empty. Ranks occupy the channel-local space in ascending order from rank 0.
- R4: `out_mode` is 0 when at most one channel is populated, 1 when both totals are equal and nonzero, 2 when the totals differ and `cfg_lshape`=0, and 3 when the totals differ and `cfg_lshape`=1.
- R5: In mode 0 the address goes unchanged to the populated channel. It goes to channel 0 if that is the only one populated, otherwise to channel 1.
- R6: In mode 1, `out_chan` equals address bit 6. `out_addr` is the address with bit 6 removed: bits [5:0] are kept and the bits above 6 shift down by one. `cfg_lshape` has no effect.
- R7: In mode 2, addresses below the channel-0 total go unchanged to channel 0. Higher addresses go to channel 1 with the channel-0 total subtracted.
- R8: In mode 3 the zone below twice the smaller total is interleaved as in R6. Above that zone, addresses go to the larger channel with the smaller total subtracted.
- R9: `out_rank` is the lowest rank k for which the channel-local address is below the cumulative top of ranks 0..k of the selected channel. Empty ranks are therefore skipped.
- R10: An address at or above the sum of both channel totals sets `out_oor` and forces `out_chan`, `out_addr` and `out_rank` to zero. This holds in every mode, including when no memory is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input address is valid this cycle |
| in_addr | input | 32 | System physical byte address |
| cfg_cap0 | input | 8 | Rank capacity codes of channel 0 |
| cfg_cap1 | input | 8 | Rank capacity codes of channel 1 |
| cfg_lshape | input | 1 | Unequal totals: 0 stacked, 1 L-shaped |
| out_valid | output | 1 | Registered result is valid |
| out_chan | output | 1 | Selected channel |
| out_addr | output | 32 | Channel-local byte address |
| out_rank | output | 2 | Selected rank in that channel |
| out_oor | output | 1 | Address beyond populated memory |
| out_mode | output | 2 | Mapping mode in force |

## Verification
A wrong mode decision or a wrong channel total shows up one cycle after the request. It appears on `out_mode`, or as a channel or local address that is wrong only on one side of a region boundary. For that reason the vectors sit on both sides of every boundary: the channel-0 top, the L-shaped zone edge and the overall memory limit. A wrong cumulative rank table changes `out_rank` only for addresses near a rank edge. Configurations with an empty or reserved rank in the middle expose a table that fails to skip it.

// File: rtl/dcam_pkg.sv
package dcam_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_SYM    = 2'd1,
      MODE_STACK  = 2'd2,
      MODE_LSHAPE = 2'd3
   } map_mode_e;

   // capacity code to 256 MB units; the reserved code counts as empty
   function automatic logic [1:0] cap_units(input logic [1:0] code);
      return (code == 2'd3) ? 2'd0 : code;
   endfunction

endpackage

// File: rtl/dcam_rank_table.sv
module dcam_rank_table #(
   parameter int RANKS = 4,
   parameter int UW    = 5
) (
   input  logic [2*RANKS-1:0]        cap,
   output logic [RANKS-1:0][UW-1:0]  tops,
   output logic [UW-1:0]             total
);
   import dcam_pkg::*;

   for (genvar k = 0; k < RANKS; k++) begin : g_rank
      logic [UW-1:0] units_k;
      assign units_k = UW'(cap_units(cap[2*k+1 -: 2]));
      if (k == 0) begin : g_first
         assign tops[k] = units_k;
      end else begin : g_next
         assign tops[k] = tops[k-1] + units_k;
      end
   end

   assign total = tops[RANKS-1];

endmodule

// File: rtl/dcam_mode_sel.sv
module dcam_mode_sel #(
   parameter int UW = 5
) (
   input  logic [UW-1:0]        tot0,
   input  logic [UW-1:0]        tot1,
   input  logic                 lshape,
   output dcam_pkg::map_mode_e  mode,
   output logic                 small_ch,
   output logic [UW-1:0]        small_tot
);
   import dcam_pkg::*;

   always_comb begin
      if (tot0 == '0 || tot1 == '0)  mode = MODE_SINGLE;
      else if (tot0 == tot1)         mode = MODE_SYM;
      else if (lshape)               mode = MODE_LSHAPE;
      else                           mode = MODE_STACK;
   end

   assign small_ch  = (tot1 < tot0);
   assign small_tot = small_ch ? tot1 : tot0;

endmodule

// File: rtl/dcam_xlate.sv
module dcam_xlate #(
   parameter int ADDR_W     = 32,
   parameter int UNIT_SHIFT = 28,
   parameter int LINE_SHIFT = 6,
   parameter int UW         = 5
) (
   input  logic [ADDR_W-1:0]    addr,
   input  dcam_pkg::map_mode_e  mode,
   input  logic [UW-1:0]        tot0,
   input  logic [UW-1:0]        tot1,
   input  logic                 small_ch,
   input  logic [UW-1:0]        small_tot,
   output logic                 chan,
   output logic [ADDR_W-1:0]    local_addr,
   output logic                 oor
);
   import dcam_pkg::*;

   localparam int HI_W = ADDR_W - UNIT_SHIFT;

   logic [UW-1:0]     hi;
   logic [UW-1:0]     sum_tot;
   logic [UW-1:0]     zone;
   logic [UW-1:0]     hi_minus0;
   logic [UW-1:0]     hi_minus_s;
   logic [ADDR_W-1:0] intl_addr;

   assign hi         = UW'(addr[ADDR_W-1:UNIT_SHIFT]);
   assign sum_tot    = tot0 + tot1;
   assign zone       = small_tot << 1;
   assign hi_minus0  = hi - tot0;
   assign hi_minus_s = hi - small_tot;
   assign intl_addr  = {1'b0, addr[ADDR_W-1:LINE_SHIFT+1], addr[LINE_SHIFT-1:0]};

   always_comb begin
      chan       = 1'b0;
      local_addr = addr;
      oor        = (hi >= sum_tot);
      unique case (mode)
         MODE_SINGLE: begin
            chan = (tot0 == '0);
         end
         MODE_SYM: begin
            chan       = addr[LINE_SHIFT];
            local_addr = intl_addr;
         end
         MODE_STACK: begin
            if (hi >= tot0) begin
               chan       = 1'b1;
               local_addr = {hi_minus0[HI_W-1:0], addr[UNIT_SHIFT-1:0]};
            end
         end
         MODE_LSHAPE: begin
            if (hi < zone) begin
               chan       = addr[LINE_SHIFT];
               local_addr = intl_addr;
            end else begin
               chan       = ~small_ch;
               local_addr = {hi_minus_s[HI_W-1:0], addr[UNIT_SHIFT-1:0]};
            end
         end
         default: ;
      endcase
      if (oor) begin
         chan       = 1'b0;
         local_addr = '0;
      end
   end

endmodule

// File: rtl/dcam_rank_find.sv
module dcam_rank_find #(
   parameter int RANKS  = 4,
   parameter int UW     = 5,
   parameter int RANK_W = 2
) (
   input  logic [UW-1:0]             loc_hi,
   input  logic [RANKS-1:0][UW-1:0]  tops,
   output logic [RANK_W-1:0]         rank
);

   always_comb begin
      rank = '0;
      for (int k = RANKS - 1; k >= 0; k--) begin
         if (loc_hi < tops[k]) rank = RANK_W'(k);
      end
   end

endmodule

// File: rtl/dcam_addr_mapper.sv
module dcam_addr_mapper #(
   parameter int ADDR_W     = 32,
   parameter int UNIT_SHIFT = 28,
   parameter int LINE_SHIFT = 6,
   parameter int RANKS      = 4,
   localparam int RANK_W    = (RANKS > 1) ? $clog2(RANKS) : 1,
   localparam int CAP_W     = 2 * RANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [CAP_W-1:0]  cfg_cap0,
   input  logic [CAP_W-1:0]  cfg_cap1,
   input  logic              cfg_lshape,
   output logic              out_valid,
   output logic              out_chan,
   output logic [ADDR_W-1:0] out_addr,
   output logic [RANK_W-1:0] out_rank,
   output logic              out_oor,
   output logic [1:0]        out_mode
);
   import dcam_pkg::*;

   localparam int HI_W = ADDR_W - UNIT_SHIFT;
   localparam int UW   = HI_W + 1;

   if (UNIT_SHIFT <= LINE_SHIFT + 1) begin : g_bad_shift
      $error("UNIT_SHIFT must exceed LINE_SHIFT + 1");
   end
   if (4 * RANKS > (1 << HI_W)) begin : g_bad_space
      $error("full population must fit the address space");
   end

   logic [1:0][CAP_W-1:0]            caps;
   logic [1:0][RANKS-1:0][UW-1:0]    tops;
   logic [1:0][UW-1:0]               tot;

   assign caps[0] = cfg_cap0;
   assign caps[1] = cfg_cap1;

   for (genvar c = 0; c < 2; c++) begin : g_chan
      dcam_rank_table #(.RANKS(RANKS), .UW(UW)) table_i (
         .cap   (caps[c]),
         .tops  (tops[c]),
         .total (tot[c])
      );
   end

   map_mode_e         mode_c;
   logic              small_ch;
   logic [UW-1:0]     small_tot;

   dcam_mode_sel #(.UW(UW)) mode_i (
      .tot0      (tot[0]),
      .tot1      (tot[1]),
      .lshape    (cfg_lshape),
      .mode      (mode_c),
      .small_ch  (small_ch),
      .small_tot (small_tot)
   );

   logic              chan_c;
   logic [ADDR_W-1:0] loc_c;
   logic              oor_c;

   dcam_xlate #(
      .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT), .LINE_SHIFT(LINE_SHIFT), .UW(UW)
   ) xlate_i (
      .addr       (in_addr),
      .mode       (mode_c),
      .tot0       (tot[0]),
      .tot1       (tot[1]),
      .small_ch   (small_ch),
      .small_tot  (small_tot),
      .chan       (chan_c),
      .local_addr (loc_c),
      .oor        (oor_c)
   );

   logic [UW-1:0]            loc_hi;
   logic [RANKS-1:0][UW-1:0] tops_sel;
   logic [RANK_W-1:0]        rank_c;

   assign loc_hi   = UW'(loc_c[ADDR_W-1:UNIT_SHIFT]);
   assign tops_sel = tops[chan_c];

   dcam_rank_find #(.RANKS(RANKS), .UW(UW), .RANK_W(RANK_W)) rank_i (
      .loc_hi (loc_hi),
      .tops   (tops_sel),
      .rank   (rank_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= 1'b0;
         out_addr  <= '0;
         out_rank  <= '0;
         out_oor   <= 1'b0;
         out_mode  <= 2'd0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_chan <= chan_c;
            out_addr <= loc_c;
            out_rank <= oor_c ? '0 : rank_c;
            out_oor  <= oor_c;
            out_mode <= mode_c;
         end
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_chan)));
   // R6
   sym_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_c == MODE_SYM && !oor_c) |=> (out_chan == $past(in_addr[LINE_SHIFT])));
   // R5
   single_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && tot[0] == '0 && tot[1] != '0 && !oor_c) |=> out_chan);
   // R9
   rank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !oor_c) |-> (loc_hi < tops_sel[rank_c] &&
                                (rank_c == '0 || loc_hi >= tops_sel[rank_c - 1'b1])));
   // R10
   oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_oor) |-> (out_addr == '0 && out_rank == '0 && !out_chan));

endmodule

// File: tb/dcam_addr_mapper_tb.sv
module dcam_addr_mapper_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_addr = '0;
   logic [7:0]  cfg_cap0 = '0;
   logic [7:0]  cfg_cap1 = '0;
   logic        cfg_lshape = 1'b0;
   logic        out_valid;
   logic        out_chan;
   logic [31:0] out_addr;
   logic [1:0]  out_rank;
   logic        out_oor;
   logic [1:0]  out_mode;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcam_addr_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .cfg_cap0(cfg_cap0), .cfg_cap1(cfg_cap1), .cfg_lshape(cfg_lshape),
      .out_valid(out_valid), .out_chan(out_chan), .out_addr(out_addr),
      .out_rank(out_rank), .out_oor(out_oor), .out_mode(out_mode)
   );

   typedef struct packed {
      logic [7:0]  c0;
      logic [7:0]  c1;
      logic        lsh;
      logic [31:0] addr;
      logic        chan;
      logic [31:0] loc;
      logic [1:0]  rank;
      logic        oor;
      logic [1:0]  mode;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      // R6 equal totals 1280 MB each
      '{8'h1A, 8'h1A, 1'b0, 32'h0000_0040, 1'b1, 32'h0000_0000, 2'd0, 1'b0, 2'd1, 4'd6},
      '{8'h1A, 8'h1A, 1'b0, 32'h0000_0080, 1'b0, 32'h0000_0040, 2'd0, 1'b0, 2'd1, 4'd6},
      // R9
      '{8'h1A, 8'h1A, 1'b0, 32'h4000_0040, 1'b1, 32'h2000_0000, 2'd1, 1'b0, 2'd1, 4'd9},
      '{8'h1A, 8'h1A, 1'b0, 32'h9000_0000, 1'b0, 32'h4800_0000, 2'd2, 1'b0, 2'd1, 4'd9},
      // R10
      '{8'h1A, 8'h1A, 1'b0, 32'hA000_0000, 1'b0, 32'h0000_0000, 2'd0, 1'b1, 2'd1, 4'd10},
      '{8'h1A, 8'h1A, 1'b0, 32'h9FFF_FFFF, 1'b1, 32'h4FFF_FFFF, 2'd2, 1'b0, 2'd1, 4'd10},
      // R7 totals 1280 / 1024
      '{8'h1A, 8'h0A, 1'b0, 32'h4FFF_FFFF, 1'b0, 32'h4FFF_FFFF, 2'd2, 1'b0, 2'd2, 4'd7},
      '{8'h1A, 8'h0A, 1'b0, 32'h5000_0000, 1'b1, 32'h0000_0000, 2'd0, 1'b0, 2'd2, 4'd7},
      '{8'h1A, 8'h0A, 1'b0, 32'h8000_0100, 1'b1, 32'h3000_0100, 2'd1, 1'b0, 2'd2, 4'd7},
      '{8'h1A, 8'h0A, 1'b0, 32'h9000_0000, 1'b0, 32'h0000_0000, 2'd0, 1'b1, 2'd2, 4'd10},
      '{8'h1A, 8'h0A, 1'b0, 32'h1000_0000, 1'b0, 32'h1000_0000, 2'd0, 1'b0, 2'd2, 4'd7},
      // R8 totals 1024 / 1280, larger on channel 1
      '{8'h0A, 8'h1A, 1'b1, 32'h0000_0040, 1'b1, 32'h0000_0000, 2'd0, 1'b0, 2'd3, 4'd8},
      '{8'h0A, 8'h1A, 1'b1, 32'h7FFF_FF80, 1'b0, 32'h3FFF_FFC0, 2'd1, 1'b0, 2'd3, 4'd8},
      '{8'h0A, 8'h1A, 1'b1, 32'h8000_0000, 1'b1, 32'h4000_0000, 2'd2, 1'b0, 2'd3, 4'd8},
      '{8'h0A, 8'h1A, 1'b1, 32'h8FFF_FFFC, 1'b1, 32'h4FFF_FFFC, 2'd2, 1'b0, 2'd3, 4'd8},
      '{8'h0A, 8'h1A, 1'b1, 32'h9000_0000, 1'b0, 32'h0000_0000, 2'd0, 1'b1, 2'd3, 4'd10},
      // R8 larger on channel 0
      '{8'h1A, 8'h0A, 1'b1, 32'h8000_0040, 1'b0, 32'h4000_0040, 2'd2, 1'b0, 2'd3, 4'd8},
      '{8'h1A, 8'h0A, 1'b1, 32'h0000_00C0, 1'b1, 32'h0000_0040, 2'd0, 1'b0, 2'd3, 4'd8},
      // R5 channel 1 only, then channel 0 only
      '{8'h00, 8'h0A, 1'b0, 32'h3000_0040, 1'b1, 32'h3000_0040, 2'd1, 1'b0, 2'd0, 4'd5},
      '{8'h00, 8'h0A, 1'b0, 32'h4000_0000, 1'b0, 32'h0000_0000, 2'd0, 1'b1, 2'd0, 4'd10},
      '{8'h1A, 8'h00, 1'b1, 32'h4000_0000, 1'b0, 32'h4000_0000, 2'd2, 1'b0, 2'd0, 4'd5},
      // R6 lshape bit ignored with equal totals
      '{8'h1A, 8'h1A, 1'b1, 32'h9000_0000, 1'b0, 32'h4800_0000, 2'd2, 1'b0, 2'd1, 4'd6},
      // R3 reserved code in rank 1 is empty; equal totals of 1024 MB
      '{8'h2E, 8'h0A, 1'b0, 32'h4000_0000, 1'b0, 32'h2000_0000, 2'd2, 1'b0, 2'd1, 4'd3},
      '{8'h2E, 8'h0A, 1'b0, 32'h8000_0000, 1'b0, 32'h0000_0000, 2'd0, 1'b1, 2'd1, 4'd3}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic send(input logic [7:0] c0, input logic [7:0] c1,
                       input logic lsh, input logic [31:0] a);
      @(negedge clk);
      cfg_cap0 = c0; cfg_cap1 = c1; cfg_lshape = lsh;
      in_addr = a; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1 outputs during and after reset
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", {31'd0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after reset", {31'd0, out_valid}, 32'd0);
      chk("R1", "addr after reset", out_addr, 32'd0);
      chk("R1", "mode/rank/oor", {26'd0, out_mode, out_rank, out_oor, out_chan}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = $sformatf("R%0d", VECS[i].req);
         send(VECS[i].c0, VECS[i].c1, VECS[i].lsh, VECS[i].addr);
         chk("R2", "valid", {31'd0, out_valid}, 32'd1);
         chk(rq, $sformatf("v%0d chan", i), {31'd0, out_chan}, {31'd0, VECS[i].chan});
         chk(rq, $sformatf("v%0d addr", i), out_addr, VECS[i].loc);
         chk(rq, $sformatf("v%0d rank", i), {30'd0, out_rank}, {30'd0, VECS[i].rank});
         chk(rq, $sformatf("v%0d oor", i), {31'd0, out_oor}, {31'd0, VECS[i].oor});
         // R4
         chk("R4", $sformatf("v%0d mode", i), {30'd0, out_mode}, {30'd0, VECS[i].mode});
      end

      // R2 idle cycle: valid drops, previous result held
      send(8'h0A, 8'h1A, 1'b1, 32'h8000_0000);
      @(negedge clk);
      in_addr = 32'h0000_0040;
      @(negedge clk);
      chk("R2", "idle valid", {31'd0, out_valid}, 32'd0);
      chk("R2", "idle hold addr", out_addr, 32'h4000_0000);
      chk("R2", "idle hold chan", {31'd0, out_chan}, 32'd1);

      // R10 no memory at all
      send(8'h00, 8'h00, 1'b0, 32'h0000_0000);
      chk("R10", "empty oor", {31'd0, out_oor}, 32'd1);
      chk("R4", "empty mode", {30'd0, out_mode}, 32'd0);

      // R3 reserved codes everywhere mean no memory
      send(8'hFF, 8'hFF, 1'b0, 32'h0000_1000);
      chk("R3", "reserved oor", {31'd0, out_oor}, 32'd1);

      // R9 empty rank 0 skipped: ch1 only, ranks 1 and 2 at 256 MB
      send(8'h00, 8'h14, 1'b0, 32'h0000_0000);
      chk("R9", "skip empty rank", {30'd0, out_rank}, 32'd1);
      send(8'h00, 8'h14, 1'b0, 32'h1000_0000);
      chk("R9", "second rank", {30'd0, out_rank}, 32'd2);

      // R1 reset in mid-run clears outputs
      send(8'h1A, 8'h0A, 1'b0, 32'h8000_0100);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "reset clears addr", out_addr, 32'd0);
      chk("R1", "reset clears chan", {31'd0, out_chan}, 32'd0);
      rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule